// File: doc/BRIEF.md
# Coupled Saturating Cache Hit/Miss Counters

This block keeps four event counters for a cache: hits and misses for reads, and hits and misses for writes. Each event arrives as a single-cycle strobe. The counts are packed into two 32-bit views. One view holds the read counters and the other holds the write counters. In each view the hit count fills the upper field and the miss count fills the lower field.

Software resets a view by writing zero to it. The four counters saturate together. As soon as any one of them holds its all-ones value, none of them advances. This keeps the hit/miss ratios consistent. Counting starts again on its own once no counter sits at its maximum, which normally happens after software clears the saturated one.

Top module: `cache_perf_counters`

## Requirements
- R1: On a synchronous active-high reset, all four counters are zero, so both views read 0.
- R2: In each view, the hit count occupies bits 31:12 (20 bits) and the miss count occupies bits 11:0 (12 bits).
- R3: A strobe that is high during a clock cycle adds exactly one to its counter, and the change is visible after that edge. A strobe held high adds one per cycle. Several strobes in the same cycle each advance their own counter.
- R4: While any of the four counters holds its all-ones value, no strobe changes any counter.
- R5: A write of zero clears both counters of the selected view on the next edge and leaves the other view untouched. The select bit `sw_sel_i` is 0 for the read view and 1 for the write view.
- R6: A write of any nonzero value leaves every counter unchanged.
- R7: When a clear and a strobe for the same view fall in the same cycle, the clear wins and the counter reads zero.
- R8: A clear takes effect even while the counters are frozen. Clearing a view that does not hold the saturated counter keeps the freeze in place. Once no counter is at all-ones, strobes count again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_hit_i | input | 1 | Read-hit event strobe |
| rd_miss_i | input | 1 | Read-miss event strobe |
| wr_hit_i | input | 1 | Write-hit event strobe |
| wr_miss_i | input | 1 | Write-miss event strobe |
| sw_we_i | input | 1 | Software write enable for a view |
| sw_sel_i | input | 1 | View select: 0 read view, 1 write view |
| sw_wdata_i | input | 32 | Software write data; only zero acts |
| rd_view_o | output | 32 | Read view: hit count in bits 31:12, miss count in bits 11:0 |
| wr_view_o | output | 32 | Write view: hit count in bits 31:12, miss count in bits 11:0 |

## Verification
The counters are directly visible at the ports, so a corrupted count shows up in the view on the very next edge after the faulty update. A wrong freeze decision has two visible forms. If the counters stop too early, a view fails to advance in the cycle after a strobe. If they fail to stop, the saturated miss field wraps to zero or another field moves while a counter sits at all-ones. A stale freeze that outlives the clear of the saturated view is also caught at the ports: the first strobe after that clear fails to count in the following cycle.

// File: rtl/hm_cnt_pkg.sv
package hm_cnt_pkg;

    // Default field widths of one packed view.
    localparam int HIT_BITS  = 20;
    localparam int MISS_BITS = 12;
    localparam int VIEW_BITS = HIT_BITS + MISS_BITS;
    localparam int N_VIEWS   = 2;

    // View selector encoding.
    typedef enum logic {
        VIEW_READ  = 1'b0,
        VIEW_WRITE = 1'b1
    } view_sel_e;

    // Events destined for one view in a single cycle.
    typedef struct packed {
        logic hit;
        logic miss;
    } view_evt_t;

    // A software write that carries zero requests a clear.
    function automatic logic is_clear_req(input logic we, input logic [VIEW_BITS-1:0] data);
        return we && (data == '0);
    endfunction

endpackage

// File: rtl/hm_sat_counter.sv
module hm_sat_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic         hold_i,
    output logic [W-1:0] cnt_o,
    output logic         full_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && !hold_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign full_o = &cnt_q;

    // R3
    inc_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !hold_i && !clr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R4
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_i && !clr_i) |=> $stable(cnt_o));

    // R7
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/hm_view_pair.sv
module hm_view_pair
    import hm_cnt_pkg::*;
#(
    parameter int HW = HIT_BITS,
    parameter int MW = MISS_BITS,
    localparam int VW = HW + MW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  view_evt_t     evt_i,
    input  logic          hold_i,
    output logic [VW-1:0] view_o,
    output logic          full_o
);

    logic [HW-1:0] hit_cnt;
    logic [MW-1:0] miss_cnt;
    logic          hit_full;
    logic          miss_full;

    hm_sat_counter #(.W(HW)) u_hit (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr_i),
        .inc_i  (evt_i.hit),
        .hold_i (hold_i),
        .cnt_o  (hit_cnt),
        .full_o (hit_full)
    );

    hm_sat_counter #(.W(MW)) u_miss (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr_i),
        .inc_i  (evt_i.miss),
        .hold_i (hold_i),
        .cnt_o  (miss_cnt),
        .full_o (miss_full)
    );

    // Hit count in the upper field, miss count in the lower field.
    assign view_o = {hit_cnt, miss_cnt};
    assign full_o = hit_full | miss_full;

    // R5
    view_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (view_o == '0));

endmodule

// File: rtl/cache_perf_counters.sv
module cache_perf_counters
    import hm_cnt_pkg::*;
#(
    parameter int HIT_W  = HIT_BITS,
    parameter int MISS_W = MISS_BITS,
    localparam int VIEW_W = HIT_W + MISS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hit_i,
    input  logic              rd_miss_i,
    input  logic              wr_hit_i,
    input  logic              wr_miss_i,
    input  logic              sw_we_i,
    input  logic              sw_sel_i,
    input  logic [VIEW_W-1:0] sw_wdata_i,
    output logic [VIEW_W-1:0] rd_view_o,
    output logic [VIEW_W-1:0] wr_view_o
);

    view_evt_t         evt   [N_VIEWS];
    logic [VIEW_W-1:0] view  [N_VIEWS];
    logic [N_VIEWS-1:0] clr;
    logic [N_VIEWS-1:0] full;
    logic               freeze;
    logic               zero_wr;

    assign evt[VIEW_READ]  = '{hit: rd_hit_i, miss: rd_miss_i};
    assign evt[VIEW_WRITE] = '{hit: wr_hit_i, miss: wr_miss_i};

    assign zero_wr = (sw_wdata_i == '0) && sw_we_i;

    // Shared freeze: any counter at all-ones stops all of them.
    assign freeze = |full;

    for (genvar g = 0; g < N_VIEWS; g++) begin : g_view
        assign clr[g] = zero_wr && (sw_sel_i == 1'(g));

        hm_view_pair #(.HW(HIT_W), .MW(MISS_W)) u_pair (
            .clk    (clk),
            .rst    (rst),
            .clr_i  (clr[g]),
            .evt_i  (evt[g]),
            .hold_i (freeze),
            .view_o (view[g]),
            .full_o (full[g])
        );
    end

    assign rd_view_o = view[VIEW_READ];
    assign wr_view_o = view[VIEW_WRITE];

    // R4
    all_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze && !zero_wr) |=> ($stable(rd_view_o) && $stable(wr_view_o)));

    // R6
    nz_write_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_we_i && sw_wdata_i != '0 && !rd_hit_i && !rd_miss_i && !wr_hit_i && !wr_miss_i)
        |=> ($stable(rd_view_o) && $stable(wr_view_o)));

    // R5
    other_view_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_wr && !sw_sel_i && !wr_hit_i && !wr_miss_i) |=> $stable(wr_view_o));

endmodule

// File: tb/sim_cache_perf_counters.sv
`timescale 1ns/1ps
module sim_cache_perf_counters;

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_hit_i, rd_miss_i, wr_hit_i, wr_miss_i;
    logic        sw_we_i, sw_sel_i;
    logic [31:0] sw_wdata_i;
    logic [31:0] rd_view_o, wr_view_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cache_perf_counters u0 (
        .clk        (clk),
        .rst        (rst),
        .rd_hit_i   (rd_hit_i),
        .rd_miss_i  (rd_miss_i),
        .wr_hit_i   (wr_hit_i),
        .wr_miss_i  (wr_miss_i),
        .sw_we_i    (sw_we_i),
        .sw_sel_i   (sw_sel_i),
        .sw_wdata_i (sw_wdata_i),
        .rd_view_o  (rd_view_o),
        .wr_view_o  (wr_view_o)
    );

    function automatic logic [31:0] pack(input int h, input int m);
        return {h[19:0], m[11:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, driven and then sampled at the falling edge.
    task automatic cyc(input logic rh, input logic rm, input logic wh, input logic wm,
                       input logic we, input logic sel, input logic [31:0] d);
        rd_hit_i = rh; rd_miss_i = rm; wr_hit_i = wh; wr_miss_i = wm;
        sw_we_i = we; sw_sel_i = sel; sw_wdata_i = d;
        @(negedge clk);
        rd_hit_i = 0; rd_miss_i = 0; wr_hit_i = 0; wr_miss_i = 0;
        sw_we_i = 0; sw_sel_i = 0; sw_wdata_i = '0;
    endtask

    task automatic clear_all();
        cyc(0,0,0,0, 1, 0, 32'h0);
        cyc(0,0,0,0, 1, 1, 32'h0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cyc(1,1,1,1, 0, 0, 32'h0);
        cyc(0,0,0,0, 0, 0, 32'h0);
        rst = 1'b0;
        check("R1 read view after reset", rd_view_o, 32'h0);
        check("R1 write view after reset", wr_view_o, 32'h0);
    endtask

    task automatic t_count();
        for (int i = 0; i < 5; i++) cyc(1,0,0,0, 0,0,32'h0);
        for (int i = 0; i < 3; i++) cyc(0,1,0,0, 0,0,32'h0);
        for (int i = 0; i < 7; i++) cyc(0,0,1,0, 0,0,32'h0);
        for (int i = 0; i < 2; i++) cyc(0,0,0,1, 0,0,32'h0);
        check("R2 read view packing", rd_view_o, pack(5, 3));
        check("R2 write view packing", wr_view_o, pack(7, 2));
        cyc(1,1,1,1, 0,0,32'h0);
        check("R3 simultaneous strobes read", rd_view_o, pack(6, 4));
        check("R3 simultaneous strobes write", wr_view_o, pack(8, 3));
        // Strobe held high for 20 cycles adds one per cycle
        for (int i = 0; i < 20; i++) cyc(0,1,0,0, 0,0,32'h0);
        check("R3 held strobe", rd_view_o, pack(6, 24));
    endtask

    task automatic t_clear();
        cyc(0,0,0,0, 1, 0, 32'h0);
        check("R5 read view cleared", rd_view_o, 32'h0);
        check("R5 write view untouched", wr_view_o, pack(8, 3));
        cyc(0,0,0,0, 1, 1, 32'h0);
        check("R5 write view cleared", wr_view_o, 32'h0);
    endtask

    task automatic t_nonzero();
        cyc(1,0,0,1, 0,0,32'h0);
        cyc(0,0,0,0, 1, 0, 32'h0000_1001);
        check("R6 nonzero write read view", rd_view_o, pack(1, 0));
        cyc(0,0,0,0, 1, 1, 32'hFFFF_FFFF);
        check("R6 nonzero write write view", wr_view_o, pack(0, 1));
    endtask

    task automatic t_clear_wins();
        cyc(1,1,0,0, 1, 0, 32'h0);
        check("R7 clear beats read events", rd_view_o, 32'h0);
        cyc(0,0,1,1, 1, 1, 32'h0);
        check("R7 clear beats write events", wr_view_o, 32'h0);
    endtask

    task automatic t_saturate();
        clear_all();
        for (int i = 0; i < 4095; i++) cyc(0,0,0,1, 0,0,32'h0);
        check("R4 write miss at all-ones", wr_view_o, pack(0, 4095));
        for (int i = 0; i < 10; i++) cyc(1,1,1,1, 0,0,32'h0);
        check("R4 frozen write view", wr_view_o, pack(0, 4095));
        check("R4 frozen read view", rd_view_o, 32'h0);
        // Clearing the other view keeps the freeze in place
        cyc(0,0,0,0, 1, 0, 32'h0);
        cyc(1,0,0,0, 0,0,32'h0);
        check("R8 freeze kept after other clear", rd_view_o, 32'h0);
        // Clear the saturated view, then counting resumes
        cyc(0,0,0,0, 1, 1, 32'h0);
        check("R8 saturated view cleared", wr_view_o, 32'h0);
        cyc(1,0,0,1, 0,0,32'h0);
        check("R8 resume read", rd_view_o, pack(1, 0));
        check("R8 resume write", wr_view_o, pack(0, 1));
    endtask

    initial begin
        rst = 1'b1;
        rd_hit_i = 0; rd_miss_i = 0; wr_hit_i = 0; wr_miss_i = 0;
        sw_we_i = 0; sw_sel_i = 0; sw_wdata_i = '0;
        @(negedge clk);
        t_reset();
        t_count();
        t_clear();
        t_nonzero();
        t_clear_wins();
        t_saturate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule